// File: doc/BRIEF.md
# Serial Flash Erase Sequencer

This controller sits on the host side of a single-data-line serial flash and carries out a full erase transaction by itself. A one-cycle request selects either an erase of the whole device or an erase of one sector and supplies a 24-bit byte address. The controller then runs three kinds of chip-select frames in order:

- a write-enable frame;
- the erase frame;
- a repeated status read that watches the write-in-progress flag until the self-timed erase inside the flash has finished.

While it works, `busy` stays high. At the end it pulses `done`, and if the flag never cleared it also pulses `timeout_err`.

The serial side uses SPI mode 0. The clock idles low while chip-select is high, the controller changes its data output only while the clock is low, and both the flash and the controller sample on the rising clock edge. Each clock half-period lasts `CLK_DIV` system clocks. Chip-select goes high on the falling edge that ends the last bit of a frame, because the flash starts its erase on that rising chip-select edge. Between frames chip-select stays high for at least `CS_GAP` system clocks. Before each status read it stays high for at least the larger of `CS_GAP` and `POLL_GAP`.

Top module: `flash_erase_seq`

## Requirements
- R1: After reset, spi_cs_n is 1, spi_sck is 0, and busy, done and timeout_err are 0.
- R2: Every transaction starts with a frame of exactly 8 bits carrying the write-enable opcode 0x06. This frame is closed on its own before any erase frame.
- R3: When req_chip is 1, the second frame is exactly 8 bits and carries the opcode 0xC7, with no address after it.
- R4: When req_chip is 0, the second frame is exactly 32 bits: the opcode 0xD8 followed by req_addr[23:0], most significant bit first. The address is taken as given, so any byte inside the sector is allowed.
- R5: SPI mode 0 holds throughout. spi_sck is 0 whenever spi_cs_n is 1. spi_mosi does not change while spi_sck is high. Each high phase of spi_sck lasts CLK_DIV system clocks.
- R6: spi_cs_n rises exactly CLK_DIV system clocks after the last rising spi_sck edge of a frame, with spi_sck low.
- R7: Between any two frames, spi_cs_n stays high for at least CS_GAP system clocks.
- R8: After the erase frame, the controller sends 16-bit status-read frames. Each frame carries the opcode 0x05 in its first 8 bits and reads 8 status bits from spi_miso in the last 8 bits, most significant bit first. Status bit 0 is the write-in-progress flag. Reads repeat while that flag is 1 and stop at the first read that returns 0.
- R9: Before every status-read frame, spi_cs_n stays high for at least POLL_GAP system clocks.
- R10: busy rises in the cycle after an accepted request and stays high through a single-cycle done pulse. busy is 0 in the cycle after done. When the flag clears, timeout_err stays 0.
- R11: If MAX_POLLS status reads in a row all return the flag at 1, the controller sends no further frames and pulses done together with timeout_err.
- R12: A request made while busy is 1 has no effect: it starts no frame and sends no address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe, taken only when the controller is idle |
| req_chip | input | 1 | 1 selects whole-device erase, 0 selects sector erase |
| req_addr | input | 24 | Byte address within the sector to erase |
| busy | output | 1 | High from request acceptance up to and including done |
| done | output | 1 | One-cycle pulse when the transaction ends |
| timeout_err | output | 1 | Pulses with done when polling gave up |
| spi_cs_n | output | 1 | Flash chip-select, active low |
| spi_sck | output | 1 | Serial clock to the flash |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The assertions assume that req_valid is a clean synchronous strobe. They also assume that spi_miso changes only away from the rising clock edges of a frame, the way a mode-0 flash drives it after each falling edge. The bench's flash model changes spi_miso only in the half system-clock after it sees spi_sck fall, so every rising edge samples a settled value. The model answers status reads only after a 0x05 opcode. It starts its erase only after an accepted write-enable frame and a correctly sized erase frame, so a request that slipped through while busy would show up as an extra frame.

// File: rtl/fes_pkg.sv
package fes_pkg;

  localparam int FRAME_W = 32;
  localparam int BITS_W  = $clog2(FRAME_W + 1);

  localparam logic [7:0] OPC_WREN   = 8'h06;
  localparam logic [7:0] OPC_STATUS = 8'h05;
  localparam logic [7:0] OPC_CHIP   = 8'hC7;
  localparam logic [7:0] OPC_SECTOR = 8'hD8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LAUNCH,
    ST_SHIFT,
    ST_GAP,
    ST_DONE
  } seq_state_t;

  typedef enum logic [1:0] {
    STEP_WREN,
    STEP_ERASE,
    STEP_POLL
  } seq_step_t;

  // Left-aligned word shifted out MSB first for the given step.
  function automatic logic [FRAME_W-1:0] frame_word(seq_step_t s, logic chip,
                                                    logic [23:0] addr);
    logic [FRAME_W-1:0] w;
    case (s)
      STEP_WREN:  w = {OPC_WREN, 24'h0};
      STEP_ERASE: w = chip ? {OPC_CHIP, 24'h0} : {OPC_SECTOR, addr};
      default:    w = {OPC_STATUS, 24'h0};
    endcase
    return w;
  endfunction

  // Number of clock periods in the frame for the given step.
  function automatic logic [BITS_W-1:0] frame_len(seq_step_t s, logic chip);
    logic [BITS_W-1:0] n;
    case (s)
      STEP_WREN:  n = BITS_W'(8);
      STEP_ERASE: n = chip ? BITS_W'(8) : BITS_W'(32);
      default:    n = BITS_W'(16);
    endcase
    return n;
  endfunction

  function automatic int unsigned gap_max(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic wip_flag(logic [7:0] status);
    return status[0];
  endfunction

endpackage

// File: rtl/fes_gap_timer.sv
module fes_gap_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] len,
  output logic         expired
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= len;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0) && !load;

endmodule

// File: rtl/fes_shifter.sv
module fes_shifter import fes_pkg::*; #(
  parameter int CLK_DIV = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FRAME_W-1:0] tx_word,
  input  logic [BITS_W-1:0]  n_bits,
  input  logic               miso,
  output logic               active,
  output logic               frame_end,
  output logic               bit_rise,
  output logic [7:0]         rx_byte,
  output logic               cs_n,
  output logic               sck,
  output logic               mosi
);

  localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  logic               act_q;
  logic               sck_q;
  logic               cs_q;
  logic [FRAME_W-1:0] sh_q;
  logic [BITS_W-1:0]  left_q;
  logic [DW-1:0]      div_q;
  logic [7:0]         rx_q;
  logic               div_last;

  assign div_last  = (div_q == DW'(CLK_DIV - 1));
  assign bit_rise  = act_q && !sck_q && div_last;
  assign frame_end = act_q && sck_q && div_last && (left_q == BITS_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      sck_q  <= 1'b0;
      cs_q   <= 1'b1;
      sh_q   <= '0;
      left_q <= '0;
      div_q  <= '0;
      rx_q   <= '0;
    end else if (!act_q) begin
      if (start) begin
        act_q  <= 1'b1;
        cs_q   <= 1'b0;
        sck_q  <= 1'b0;
        sh_q   <= tx_word;
        left_q <= n_bits;
        div_q  <= '0;
      end
    end else if (!div_last) begin
      div_q <= div_q + 1'b1;
    end else begin
      div_q <= '0;
      if (!sck_q) begin
        sck_q <= 1'b1;
        rx_q  <= {rx_q[6:0], miso};
      end else begin
        sck_q <= 1'b0;
        if (left_q == BITS_W'(1)) begin
          act_q <= 1'b0;
          cs_q  <= 1'b1;
        end else begin
          left_q <= left_q - 1'b1;
          sh_q   <= {sh_q[FRAME_W-2:0], 1'b0};
        end
      end
    end
  end

  assign active  = act_q;
  assign rx_byte = rx_q;
  assign cs_n    = cs_q;
  assign sck     = sck_q;
  assign mosi    = act_q ? sh_q[FRAME_W-1] : 1'b0;

endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq import fes_pkg::*; #(
  parameter int CLK_DIV   = 2,
  parameter int CS_GAP    = 4,
  parameter int POLL_GAP  = 10,
  parameter int MAX_POLLS = 20,
  parameter int GAP_W     = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_chip,
  input  logic [23:0] req_addr,
  output logic        busy,
  output logic        done,
  output logic        timeout_err,
  output logic        spi_cs_n,
  output logic        spi_sck,
  output logic        spi_mosi,
  input  logic        spi_miso
);

  localparam int PW = $clog2(MAX_POLLS + 1);
  localparam logic [GAP_W-1:0] WREN_GAP = GAP_W'(CS_GAP);
  localparam logic [GAP_W-1:0] READ_GAP = GAP_W'(gap_max(CS_GAP, POLL_GAP));

  seq_state_t  state_q;
  seq_step_t   step_q;
  logic        chip_q;
  logic [23:0] addr_q;
  logic [PW-1:0] polls_q;
  logic        err_q;

  // Named internal events, also watched by the checker.
  logic              sh_start;
  logic              sh_active;
  logic              sh_frame_end;
  logic              sh_bit_rise;
  logic [7:0]        sh_rx;
  logic              gap_load;
  logic              gap_done;
  logic              poll_clear;
  logic              poll_exhaust;
  logic              seq_finish;
  logic [GAP_W-1:0]  gap_len;
  logic [FRAME_W-1:0] tx_word;
  logic [BITS_W-1:0]  tx_bits;

  assign sh_start     = (state_q == ST_LAUNCH);
  assign tx_word      = frame_word(step_q, chip_q, addr_q);
  assign tx_bits      = frame_len(step_q, chip_q);
  assign poll_clear   = (step_q == STEP_POLL) && !wip_flag(sh_rx);
  assign poll_exhaust = (step_q == STEP_POLL) && (polls_q == PW'(MAX_POLLS - 1));
  assign seq_finish   = (state_q == ST_SHIFT) && sh_frame_end && (poll_clear || poll_exhaust);
  assign gap_load     = (state_q == ST_SHIFT) && sh_frame_end && !seq_finish;
  assign gap_len      = (step_q == STEP_WREN) ? WREN_GAP : READ_GAP;

  fes_shifter #(.CLK_DIV(CLK_DIV)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (sh_start),
    .tx_word   (tx_word),
    .n_bits    (tx_bits),
    .miso      (spi_miso),
    .active    (sh_active),
    .frame_end (sh_frame_end),
    .bit_rise  (sh_bit_rise),
    .rx_byte   (sh_rx),
    .cs_n      (spi_cs_n),
    .sck       (spi_sck),
    .mosi      (spi_mosi)
  );

  fes_gap_timer #(.W(GAP_W)) u_gap (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (gap_load),
    .len     (gap_len),
    .expired (gap_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      step_q  <= STEP_WREN;
      chip_q  <= 1'b0;
      addr_q  <= '0;
      polls_q <= '0;
      err_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            chip_q  <= req_chip;
            addr_q  <= req_addr;
            step_q  <= STEP_WREN;
            polls_q <= '0;
            err_q   <= 1'b0;
            state_q <= ST_LAUNCH;
          end
        end
        ST_LAUNCH: state_q <= ST_SHIFT;
        ST_SHIFT: begin
          if (sh_frame_end) begin
            case (step_q)
              STEP_WREN: begin
                step_q  <= STEP_ERASE;
                state_q <= ST_GAP;
              end
              STEP_ERASE: begin
                step_q  <= STEP_POLL;
                state_q <= ST_GAP;
              end
              default: begin
                polls_q <= polls_q + 1'b1;
                if (poll_clear) begin
                  state_q <= ST_DONE;
                end else if (poll_exhaust) begin
                  err_q   <= 1'b1;
                  state_q <= ST_DONE;
                end else begin
                  state_q <= ST_GAP;
                end
              end
            endcase
          end
        end
        ST_GAP: begin
          if (gap_done) state_q <= ST_LAUNCH;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy        = (state_q != ST_IDLE);
  assign done        = (state_q == ST_DONE);
  assign timeout_err = (state_q == ST_DONE) && err_q;

endmodule

// File: rtl/fes_checker.sv
module fes_checker #(
  parameter int CLK_DIV = 2,
  parameter int CS_GAP  = 4
) (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic busy,
  input logic done,
  input logic timeout_err,
  input logic cs_n,
  input logic sck,
  input logic mosi,
  input logic frame_end
);

  logic [15:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_cnt <= 16'(CS_GAP);
    else if (!cs_n) hi_cnt <= '0;
    else if (hi_cnt != 16'hFFFF) hi_cnt <= hi_cnt + 1'b1;
  end

  assert_sck_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);

  assert_mosi_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(mosi));

  assert_cs_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> (!sck && $past(frame_end)));

  assert_cs_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> (hi_cnt >= 16'(CS_GAP)));

  assert_done_in_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  assert_idle_after_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  assert_busy_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  assert_err_with_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |-> done);

  assert_accept_only_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid));

endmodule

bind flash_erase_seq fes_checker #(.CLK_DIV(CLK_DIV), .CS_GAP(CS_GAP)) u_fes_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .busy        (busy),
  .done        (done),
  .timeout_err (timeout_err),
  .cs_n        (spi_cs_n),
  .sck         (spi_sck),
  .mosi        (spi_mosi),
  .frame_end   (sh_frame_end)
);

// File: tb/tb_flash_erase_seq.sv
module tb_flash_erase_seq;

  localparam int CLK_PERIOD = 10;
  localparam int CLK_DIV    = 2;
  localparam int CS_GAP     = 4;
  localparam int POLL_GAP   = 10;
  localparam int MAX_POLLS  = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_chip = 1'b0;
  logic [23:0] req_addr = '0;
  logic spi_miso = 1'b0;
  logic busy, done, timeout_err, spi_cs_n, spi_sck, spi_mosi;

  flash_erase_seq #(.CLK_DIV(CLK_DIV), .CS_GAP(CS_GAP), .POLL_GAP(POLL_GAP),
                    .MAX_POLLS(MAX_POLLS)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_chip(req_chip),
    .req_addr(req_addr), .busy(busy), .done(done), .timeout_err(timeout_err),
    .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;

  // Flash model and protocol monitor state.
  logic prev_cs = 1'b1, prev_sck = 1'b0, prev_mosi = 1'b0;
  int bitcnt = 0, hi_cnt = 0, sck_hi = 0, rise_age = 0;
  logic [31:0] cap = '0;
  logic [7:0] op = '0;
  int nframes = 0;
  logic [7:0] f_op [64];
  int f_bits [64];
  logic [23:0] f_addr [64];
  int f_gap [64];
  int viol_idle = 0, viol_mosi = 0, viol_phase = 0, viol_rise = 0;
  int done_cnt = 0;
  logic wel = 1'b0;
  int erase_left = 0;
  int erase_len = 0;
  logic [7:0] status_byte;

  assign status_byte = {6'b0, wel, (erase_left > 0)};

  always @(negedge clk) begin
    if (done) done_cnt++;
    if (spi_cs_n && spi_sck) viol_idle++;
    if (spi_sck && prev_sck && (spi_mosi != prev_mosi)) viol_mosi++;
    if (!spi_cs_n && prev_cs) begin
      bitcnt = 0; cap = '0; op = '0;
      if (nframes < 64) f_gap[nframes] = hi_cnt;
    end
    if (spi_cs_n) hi_cnt++; else hi_cnt = 0;
    if (spi_sck && !prev_sck) begin
      cap = {cap[30:0], spi_mosi};
      bitcnt++;
      if (bitcnt == 8) op = cap[7:0];
      sck_hi = 0;
      rise_age = 0;
    end else begin
      rise_age++;
    end
    if (spi_sck) sck_hi++;
    if (!spi_sck && prev_sck) begin
      if (sck_hi != CLK_DIV) viol_phase++;
      if (op == 8'h05 && bitcnt >= 8 && bitcnt < 16) spi_miso = status_byte[15 - bitcnt];
    end
    if (spi_cs_n && !prev_cs) begin
      if (spi_sck || rise_age != CLK_DIV) viol_rise++;
      if (nframes < 64) begin
        f_op[nframes]   = (bitcnt >= 8) ? op : cap[7:0];
        f_bits[nframes] = bitcnt;
        f_addr[nframes] = cap[23:0];
      end
      nframes++;
      if (op == 8'h06 && bitcnt == 8) wel = 1'b1;
      if (wel && ((op == 8'hC7 && bitcnt == 8) || (op == 8'hD8 && bitcnt == 32))) begin
        wel = 1'b0;
        erase_left = erase_len;
      end
      if (op == 8'h05 && bitcnt == 16 && erase_left > 0) erase_left--;
      spi_miso = 1'b0;
    end
    prev_cs = spi_cs_n; prev_sck = spi_sck; prev_mosi = spi_mosi;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_log(input int len);
    @(negedge clk);
    nframes = 0; viol_idle = 0; viol_mosi = 0; viol_phase = 0; viol_rise = 0;
    done_cnt = 0; erase_len = len; erase_left = 0; wel = 1'b0;
  endtask

  task automatic issue(input logic chip, input logic [23:0] addr);
    @(negedge clk);
    req_valid = 1'b1; req_chip = chip; req_addr = addr;
    @(negedge clk);
    req_valid = 1'b0;
    check(busy == 1'b1, "R10", "busy after accept", busy, 1);
  endtask

  task automatic wait_done(output logic err_seen);
    int n = 0;
    err_seen = 1'b0;
    while (!done && n < 20000) begin
      @(negedge clk);
      n++;
    end
    check(done == 1'b1, "R10", "done reached", done, 1);
    err_seen = timeout_err;
    @(negedge clk);
    check(!busy && !done, "R10", "idle after one-cycle done", {busy, done}, 0);
    check(done_cnt == 1, "R10", "done pulse count", done_cnt, 1);
  endtask

  task automatic check_frames_common(input int polls);
    check(nframes == 2 + polls, "R8", "frame count", nframes, 2 + polls);
    check(f_op[0] == 8'h06 && f_bits[0] == 8, "R2", "write-enable frame",
          {f_op[0], 8'(f_bits[0])}, {8'h06, 8'd8});
    for (int i = 2; i < nframes && i < 64; i++) begin
      if (f_op[i] != 8'h05 || f_bits[i] != 16)
        check(0, "R8", "status frame", {f_op[i], 8'(f_bits[i])}, {8'h05, 8'd16});
      if (f_gap[i] < POLL_GAP) check(0, "R9", "poll gap", f_gap[i], POLL_GAP);
    end
    check(f_gap[1] >= CS_GAP, "R7", "gap before erase", f_gap[1], CS_GAP);
    check(viol_idle == 0 && viol_mosi == 0 && viol_phase == 0, "R5", "mode 0 timing",
          viol_idle + viol_mosi + viol_phase, 0);
    check(viol_rise == 0, "R6", "chip-select rise point", viol_rise, 0);
  endtask

  task automatic t_reset;
    check(spi_cs_n == 1'b1 && spi_sck == 1'b0, "R1", "serial pins at reset",
          {spi_cs_n, spi_sck}, 2'b10);
    check(!busy && !done && !timeout_err, "R1", "status at reset",
          {busy, done, timeout_err}, 0);
  endtask

  task automatic t_chip_erase(input int len);
    logic e;
    clear_log(len);
    issue(1'b1, 24'hABCDEF);
    wait_done(e);
    check(e == 1'b0, "R10", "no timeout on clean erase", e, 0);
    check(f_op[1] == 8'hC7 && f_bits[1] == 8, "R3", "chip erase frame",
          {f_op[1], 8'(f_bits[1])}, {8'hC7, 8'd8});
    check_frames_common(len + 1);
  endtask

  task automatic t_sector_erase(input logic [23:0] addr, input int len);
    logic e;
    clear_log(len);
    issue(1'b0, addr);
    wait_done(e);
    check(e == 1'b0, "R10", "no timeout on sector erase", e, 0);
    check(f_op[1] == 8'hD8 && f_bits[1] == 32, "R4", "sector frame",
          {f_op[1], 8'(f_bits[1])}, {8'hD8, 8'd32});
    check(f_addr[1] == addr, "R4", "sector address", f_addr[1], addr);
    check_frames_common(len + 1);
  endtask

  task automatic t_ignore_busy;
    logic e;
    clear_log(4);
    issue(1'b1, 24'h0);
    repeat (100) @(negedge clk);
    req_valid = 1'b1; req_chip = 1'b0; req_addr = 24'h55AA55;
    @(negedge clk);
    req_valid = 1'b0;
    wait_done(e);
    check(nframes == 7, "R12", "no extra frames", nframes, 7);
    for (int i = 0; i < nframes && i < 64; i++)
      if (f_op[i] == 8'hD8) check(0, "R12", "stray sector frame", i, -1);
    check(f_op[1] == 8'hC7, "R12", "original erase kept", f_op[1], 8'hC7);
    repeat (60) @(negedge clk);
    check(nframes == 7 && !busy, "R12", "still idle afterwards", nframes, 7);
  endtask

  task automatic t_timeout;
    logic e;
    clear_log(100000);
    issue(1'b1, 24'h0);
    wait_done(e);
    check(e == 1'b1, "R11", "timeout flagged", e, 1);
    check(nframes == 2 + MAX_POLLS, "R11", "poll count at timeout", nframes, 2 + MAX_POLLS);
    repeat (40) @(negedge clk);
    check(nframes == 2 + MAX_POLLS, "R11", "no frames after timeout", nframes, 2 + MAX_POLLS);
    erase_left = 0;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_chip_erase(3);
    t_sector_erase(24'h12A5C3, 0);
    t_sector_erase(24'hFFFFFF, 5);
    t_ignore_busy();
    t_timeout();
    t_chip_erase(0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule